// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block runs an external eight-channel successive-approximation converter through one conversion after another without any help from outside. It drives the converter's channel address, its address-latch strobe, its start strobe and its output enable. It watches the converter's end-of-conversion line. It captures the 8-bit sample into a result register. The loop restarts as soon as a sample is stored, so a fresh result appears roughly once per conversion time, which is about 100 µs on a typical part.

The controller is a seven-state Moore machine:

- `ST_SELECT`: the channel is presented and all strobes are low.
- `ST_ADDR_LATCH`: the address-latch strobe is raised.
- `ST_CONV_START`: the address-latch strobe stays high and the start strobe is raised.
- `ST_CONV_WAIT`: all strobes are low. The machine stays here until the synchronized end-of-conversion line is high.
- `ST_DATA_EN`: output enable is raised.
- `ST_DATA_HOLD`: output enable is held.
- `ST_DATA_LOCK`: output enable is held and an internal capture strobe (`lock`) is raised for one clock.

The machine then returns to `ST_SELECT`. It moves through the transitions SELECT→ADDR_LATCH→CONV_START→CONV_WAIT on consecutive clocks. It takes CONV_WAIT→DATA_EN once end-of-conversion is seen. It then moves through DATA_EN→DATA_HOLD→DATA_LOCK→SELECT on consecutive clocks. A rising edge on `lock`, detected in the system clock domain, stores the converter data and raises `done` for one clock. Reset, or any unused state code, sends the machine to `ST_SELECT` with every strobe low.

Top module: `adc_seq_top`

## Requirements
- R1: While `rst` is high, `ale`, `start`, `oe`, `lock` and `done` are 0 and `result` is 0. The first clock after reset is spent in ST_SELECT.
- R2: `ch_addr` always equals the parameter `CHAN_SEL`, which defaults to 3'b001 (channel 1).
- R3: From ST_SELECT the machine spends one clock each in ST_ADDR_LATCH and ST_CONV_START, then enters ST_CONV_WAIT. `ale` is 1 exactly in ST_ADDR_LATCH and ST_CONV_START. `start` is 1 exactly in ST_CONV_START.
- R4: `eoc` passes through two flops before it is tested. If `eoc` is high at rising edge k, the machine may leave ST_CONV_WAIT no earlier than edge k+2. While the synchronized value is 0 it stays in ST_CONV_WAIT.
- R5: `eoc` has no effect in any state other than ST_CONV_WAIT.
- R6: `oe` is 1 exactly in ST_DATA_EN, ST_DATA_HOLD and ST_DATA_LOCK, so it is high for three consecutive clocks per conversion.
- R7: `lock` is 1 only in ST_DATA_LOCK, for exactly one clock. The next state is ST_SELECT.
- R8: `result` loads the value on `adc_data` during the ST_DATA_LOCK clock, at the edge where `lock` falls. At all other times `result` holds its value.
- R9: `done` is 1 for exactly the one clock that follows each update of `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset |
| eoc | input | 1 | End-of-conversion from the converter, asynchronous |
| adc_data | input | 8 | Converter data bus |
| ch_addr | output | 3 | Analog channel address |
| ale | output | 1 | Channel address latch strobe |
| start | output | 1 | Conversion start strobe |
| oe | output | 1 | Converter output enable |
| lock | output | 1 | Capture strobe, high in the last data state |
| result | output | 8 | Most recently captured sample |
| done | output | 1 | One-clock pulse after `result` updates |

## Verification
Two things can happen in the same cycle. The capture of a sample and the restart of the loop share one clock edge. In that cycle a still-high `eoc` can already be sitting in the synchronizer, ready to release the next ST_CONV_WAIT at once. The bench provokes this in two ways: it holds `eoc` high across whole conversions, and it also drives it randomly. In every cycle it compares `result`, `done` and all strobes against a reference model. That comparison shows that exactly one capture happens per pass and that the new pass still spends its one clock in each start-up state. The bench also asserts reset during the ST_DATA_LOCK clock, and it judges that a capture cut short this way leaves `result` cleared and produces no `done` pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_SELECT     = 3'd0,
        ST_ADDR_LATCH = 3'd1,
        ST_CONV_START = 3'd2,
        ST_CONV_WAIT  = 3'd3,
        ST_DATA_EN    = 3'd4,
        ST_DATA_HOLD  = 3'd5,
        ST_DATA_LOCK  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic ale;
        logic start;
        logic oe;
        logic lock;
    } seq_ctl_t;

    localparam seq_ctl_t CTL_IDLE = '{ale: 1'b0, start: 1'b0, oe: 1'b0, lock: 1'b0};

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge rst) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge rst) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     eoc_sync,
    output seq_ctl_t ctl
);

    seq_state_e state_q;
    seq_state_e state_d;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_SELECT;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = ST_SELECT;
        unique case (state_q)
            ST_SELECT:     state_d = ST_ADDR_LATCH;
            ST_ADDR_LATCH: state_d = ST_CONV_START;
            ST_CONV_START: state_d = ST_CONV_WAIT;
            ST_CONV_WAIT:  state_d = eoc_sync ? ST_DATA_EN : ST_CONV_WAIT;
            ST_DATA_EN:    state_d = ST_DATA_HOLD;
            ST_DATA_HOLD:  state_d = ST_DATA_LOCK;
            ST_DATA_LOCK:  state_d = ST_SELECT;
            default:       state_d = ST_SELECT;
        endcase
    end

    // Moore outputs
    always_comb begin
        ctl = CTL_IDLE;
        unique case (state_q)
            ST_SELECT:     ctl = CTL_IDLE;
            ST_ADDR_LATCH: ctl.ale = 1'b1;
            ST_CONV_START: begin
                ctl.ale   = 1'b1;
                ctl.start = 1'b1;
            end
            ST_CONV_WAIT:  ctl = CTL_IDLE;
            ST_DATA_EN:    ctl.oe = 1'b1;
            ST_DATA_HOLD:  ctl.oe = 1'b1;
            ST_DATA_LOCK: begin
                ctl.oe   = 1'b1;
                ctl.lock = 1'b1;
            end
            default:       ctl = CTL_IDLE;
        endcase
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV_WAIT && !eoc_sync) |=> (state_q == ST_CONV_WAIT)); // R4
    AST_START_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.start) |-> $past(ctl.ale)); // R3
    AST_LOCK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl.lock |=> (!ctl.lock && state_q == ST_SELECT)); // R7
    AST_OE_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.lock) |-> ($past(ctl.oe, 1) && $past(ctl.oe, 2))); // R6

endmodule

// File: rtl/adc_result_capture.sv
module adc_result_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] result,
    output logic              done
);

    logic lock_q;
    logic lock_rise;

    assign lock_rise = lock & ~lock_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            lock_q <= 1'b0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            lock_q <= lock;
            done   <= lock_rise;
            if (lock_rise) result <= din;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)); // R8

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int                 DATA_W      = 8,
    parameter int                 ADDR_W      = 3,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]  CHAN_SEL    = 3'b001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eoc,
    input  logic [DATA_W-1:0] adc_data,
    output logic [ADDR_W-1:0] ch_addr,
    output logic              ale,
    output logic              start,
    output logic              oe,
    output logic              lock,
    output logic [DATA_W-1:0] result,
    output logic              done
);

    logic     eoc_s;
    seq_ctl_t ctl;

    adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (eoc),
        .dout (eoc_s)
    );

    adc_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .eoc_sync (eoc_s),
        .ctl      (ctl)
    );

    adc_result_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .lock   (ctl.lock),
        .din    (adc_data),
        .result (result),
        .done   (done)
    );

    assign ch_addr = CHAN_SEL;
    assign ale     = ctl.ale;
    assign start   = ctl.start;
    assign oe      = ctl.oe;
    assign lock    = ctl.lock;

    AST_ADDR_CONST: assert property (@(posedge clk) disable iff (rst)
        ch_addr == CHAN_SEL); // R2

endmodule

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       eoc = 1'b0;
    logic [7:0] adc_data = 8'h00;
    logic [2:0] ch_addr;
    logic       ale, start, oe, lock, done;
    logic [7:0] result;

    int nvec  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit finished = 0;

    // reference model state
    int         m_st = 0;
    bit         m_s1 = 0, m_s2 = 0;
    logic [7:0] m_res = 8'h00;
    bit         m_done = 0;

    always #2.5 clk = ~clk;

    adc_seq_top dut (
        .clk(clk), .rst(rst), .eoc(eoc), .adc_data(adc_data),
        .ch_addr(ch_addr), .ale(ale), .start(start), .oe(oe), .lock(lock),
        .result(result), .done(done)
    );

    function automatic int next_st(int st, bit es);
        case (st)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return es ? 4 : 3;
            4: return 5;
            5: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] exp_ctl(int st); // {ale,start,oe,lock}
        return {st == 1 || st == 2, st == 2, st >= 4 && st <= 6, st == 6};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0; m_s1 = 0; m_s2 = 0; m_res = 8'h00; m_done = 0;
        end else begin
            m_done = (m_st == 6);
            if (m_st == 6) m_res = adc_data;
            m_st = next_st(m_st, m_s2);
            m_s2 = m_s1;
            m_s1 = eoc;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        logic [3:0] e;
        e = exp_ctl(m_st);
        chk("R2", "ch_addr", ch_addr, 3'b001);
        chk("R3", "ale", ale, e[3]);
        chk("R3", "start", start, e[2]);
        chk("R6", "oe", oe, e[1]);
        chk("R7", "lock", lock, e[0]);
        chk("R8", "result", result, m_res);
        chk("R9", "done", done, m_done);
    endtask

    // one clock: compare at negedge, then drive new inputs
    task automatic step(bit r, bit e, logic [7:0] d);
        @(negedge clk);
        compare_all();
        rst = r; eoc = e; adc_data = d;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        @(negedge clk);
        chk("R1", "ale", ale, 0);
        chk("R1", "start", start, 0);
        chk("R1", "oe", oe, 0);
        chk("R1", "lock", lock, 0);
        chk("R1", "done", done, 0);
        chk("R1", "result", result, 0);
        step(1, 0, 8'h00);
        step(0, 0, 8'h00);
        // R4/R5: EOC held low for a long time, machine parks in wait
        for (int i = 0; i < 40; i++) step(0, 0, 8'h11);
        // R4 directed: single-cycle EOC pulse still releases the wait
        step(0, 1, 8'h22);
        for (int i = 0; i < 12; i++) step(0, 0, 8'hA5);
        // corner: EOC held high across capture and restart
        for (int i = 0; i < 60; i++) step(0, 1, 8'(i * 7 + 3));
        // R1 corner: reset during the capture state
        for (int i = 0; i < 40 && m_st != 6; i++) step(0, 1, 8'h5C);
        step(1, 1, 8'hC3);
        step(0, 1, 8'hC3);
        for (int i = 0; i < 10; i++) step(0, 1, 8'h3C);
        // R5: EOC toggling while not waiting must change nothing (covered by model compare)
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit r;
            r = ($urandom % 500) == 0;
            step(r, ($urandom % 4) == 0, 8'($urandom));
        end
        step(0, 0, 8'h00);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule